// File: doc/BRIEF.md
# Validated Display Mode Register File

This block holds the mode settings of a linear-framebuffer display engine behind a 16-bit index/data host port. The host loads a register number with an index write, then writes or reads the data word of that register. Each data write is screened by a rule for its register. A value that breaks the rule is dropped without any report, so the stored mode is always one the display engine can use.

From the stored settings the block derives three values: the line pitch in bytes, the virtual screen height in lines (video memory size divided by the pitch), and the panned display start address in 32-bit words. The height comes from a restoring divider that takes one quotient bit per cycle. While it runs, a busy output is high and data writes are discarded. Register numbers: 0 identifier, 1 horizontal resolution, 2 vertical resolution, 3 colour depth, 4 bank, 5 virtual width, 6 virtual height (read-only), 7 X offset, 8 Y offset.

Top module: `vmode_regs`

## Requirements
- R1: After reset the identifier register reads ID_BASE, registers 1 to 8 read 0, line_pitch and start_word are 0 and busy is 0.
- R2: A write to register 0 is stored only if it equals ID_BASE, ID_BASE+1 or ID_BASE+2. Any other value leaves the register unchanged.
- R3: A write to register 1 is stored only if it is a multiple of 8 and not above MAX_X. A write to register 2 is stored only if it is not above MAX_Y.
- R4: A write of 0 to register 3 stores 8. Of the other values, only 4, 8, 15, 16, 24 and 32 are stored, and the rest are dropped.
- R5: A write to register 4 stores the value ANDed with BANKS-1.
- R6: A virtual width write below the stored horizontal resolution is dropped at once. It does not start the divider.
- R7: An accepted virtual width w gives a pitch of w/2 at depth 4, and w*((depth+7)/8) at any other depth. The virtual height is (BANKS*65536)/pitch, rounded down. It saturates at 0xFFFF, which is also the result for a pitch of 0. line_pitch and register 6 change only when the division completes.
- R8: If that height is below the stored vertical resolution, the write is rejected, and width, height and pitch keep their old values.
- R9: A write to register 7 or 8 sets start_word to (pitch*Y + xbytes)>>2. Here xbytes is X/2 at depth 4 and X*((depth+7)/8) otherwise, using the stored pitch and depth. start_word changes only on such writes.
- R10: An accepted virtual width write raises busy from the next cycle for exactly DW = clog2(BANKS)+17 cycles. Data writes made while busy is high are discarded.
- R11: rdata always shows the stored value of the indexed register. Indices above 8 read 0. Writes to register 6 are ignored.
- R12: When the index and data strobes are high in the same cycle, only the index is updated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Load wdata into the index register |
| data_we | input | 1 | Write wdata to the indexed register |
| wdata | input | 16 | Host write word |
| rdata | output | 16 | Stored value of the indexed register |
| busy | output | 1 | Virtual height division in progress |
| line_pitch | output | PW (18) | Current line pitch in bytes |
| start_word | output | SW (33) | Display start address in 32-bit words |

## Verification
Two functions can collide in the same cycle. The first is a data write arriving while the divider is still working on a virtual width. The bench issues a second width write just after an accepted one and checks two things: the stored width is the first value, and the busy window lasts exactly DW cycles. The second is an index write and a data write in the same cycle. The bench pulses both strobes together and reads back both the newly indexed register and the register that the data word would have hit, and both must be unchanged.

// File: rtl/vmode_regs.sv
module vmode_regs #(
  parameter int BANKS = 64,
  parameter int MAX_X = 1600,
  parameter int MAX_Y = 1200,
  parameter logic [15:0] ID_BASE = 16'hD0A0,
  localparam int PW = 18,
  localparam int SW = 33,
  localparam int DW = $clog2(BANKS) + 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_we,
  input  logic          data_we,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  output logic          busy,
  output logic [PW-1:0] line_pitch,
  output logic [SW-1:0] start_word
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [DW-1:0] VRAM = DW'(BANKS) << 16;
  localparam logic [15:0] BMASK = 16'(BANKS - 1);

  logic [15:0] idx_q, id_q, xres_q, yres_q, bpp_q, bank_q, vw_q, vh_q, xo_q, yo_q;
  logic [PW-1:0] pitch_q, cp;
  logic [SW-1:0] start_q;
  logic          busy_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rq;
  logic [PW-1:0] rem;
  logic [15:0]   cw;

  function automatic logic [PW-1:0] bytes_of(logic [15:0] w, logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, b} + 17'd7;
    if (b == 16'd4) return {3'b0, w[15:1]};
    return {2'b0, w} * {15'b0, s[5:3]};
  endfunction

  wire        wr_ok = data_we && !idx_we && !busy_q;
  wire [15:0] nbpp  = (wdata == 16'd0) ? 16'd8 : wdata;
  wire [15:0] sx    = (idx_q == 16'd7) ? wdata : xo_q;
  wire [15:0] sy    = (idx_q == 16'd8) ? wdata : yo_q;
  wire [SW+1:0] full = ({16'b0, pitch_q} * {18'b0, sy}) + {17'b0, bytes_of(sx, bpp_q)};

  wire [PW:0]   rem_sh = {rem, rq[DW-1]};
  wire          ge     = rem_sh >= {1'b0, cp};
  wire [PW:0]   rem_df = rem_sh - {1'b0, cp};
  wire [PW-1:0] rem_n  = ge ? rem_df[PW-1:0] : rem_sh[PW-1:0];
  wire [DW-1:0] rq_n   = {rq[DW-2:0], ge};
  wire [15:0]   vh_new = (|rq_n[DW-1:16]) ? 16'hFFFF : rq_n[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0; id_q <= ID_BASE; xres_q <= '0; yres_q <= '0; bpp_q <= '0;
      bank_q <= '0; vw_q <= '0; vh_q <= '0; xo_q <= '0; yo_q <= '0;
      pitch_q <= '0; start_q <= '0; busy_q <= 1'b0; cnt <= '0;
      rq <= '0; rem <= '0; cw <= '0; cp <= '0;
    end else begin
      if (idx_we) idx_q <= wdata;
      if (busy_q) begin
        rem <= rem_n;
        rq  <= rq_n;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy_q <= 1'b0;
          if (vh_new >= yres_q) begin
            vw_q <= cw; vh_q <= vh_new; pitch_q <= cp;
          end
        end
      end else if (wr_ok) begin
        case (idx_q)
          16'd0: if (wdata == ID_BASE || wdata == ID_BASE + 16'd1 || wdata == ID_BASE + 16'd2)
                   id_q <= wdata;
          16'd1: if (wdata <= 16'(MAX_X) && wdata[2:0] == 3'd0) xres_q <= wdata;
          16'd2: if (wdata <= 16'(MAX_Y)) yres_q <= wdata;
          16'd3: if (nbpp inside {16'd4, 16'd8, 16'd15, 16'd16, 16'd24, 16'd32}) bpp_q <= nbpp;
          16'd4: bank_q <= wdata & BMASK;
          16'd5: if (wdata >= xres_q) begin
                   cw <= wdata; cp <= bytes_of(wdata, bpp_q);
                   rq <= VRAM; rem <= '0; cnt <= CW'(DW); busy_q <= 1'b1;
                 end
          16'd7: begin xo_q <= wdata; start_q <= full[SW+1:2]; end
          16'd8: begin yo_q <= wdata; start_q <= full[SW+1:2]; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx_q)
      16'd0: rdata = id_q;
      16'd1: rdata = xres_q;
      16'd2: rdata = yres_q;
      16'd3: rdata = bpp_q;
      16'd4: rdata = bank_q;
      16'd5: rdata = vw_q;
      16'd6: rdata = vh_q;
      16'd7: rdata = xo_q;
      16'd8: rdata = yo_q;
      default: rdata = 16'd0;
    endcase
  end

  assign busy       = busy_q;
  assign line_pitch = pitch_q;
  assign start_word = start_q;
endmodule

module vmode_regs_chk #(
  parameter int MAX_X = 1600,
  parameter int PW = 18,
  parameter int SW = 33
) (
  input logic          clk,
  input logic          rst_n,
  input logic          data_we,
  input logic          busy,
  input logic [15:0]   rdata,
  input logic [15:0]   idx,
  input logic [15:0]   xres,
  input logic [15:0]   bpp,
  input logic [PW-1:0] line_pitch,
  input logic [SW-1:0] start_word
);
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(start_word));
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(data_we));
  // R7
  pitch_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_pitch) |-> $fell(busy));
  // R11
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx > 16'd8) |-> (rdata == 16'd0));
  // R3
  xres_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xres[2:0] == 3'd0) && (xres <= 16'(MAX_X)));
  // R4
  depth_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bpp inside {16'd0, 16'd4, 16'd8, 16'd15, 16'd16, 16'd24, 16'd32});
endmodule

bind vmode_regs vmode_regs_chk #(.MAX_X(MAX_X), .PW(PW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_we(data_we), .busy(busy), .rdata(rdata),
  .idx(idx_q), .xres(xres_q), .bpp(bpp_q), .line_pitch(line_pitch),
  .start_word(start_word)
);

// File: tb/sim_vmode_regs.sv
`timescale 1ns/1ps
module sim_vmode_regs;
  localparam int DW = 23;
  logic clk = 0, rst_n = 0, idx_we = 0, data_we = 0;
  logic [15:0] wdata = 0, rdata;
  logic busy;
  logic [17:0] line_pitch;
  logic [32:0] start_word;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  vmode_regs u0 (.clk(clk), .rst_n(rst_n), .idx_we(idx_we), .data_we(data_we),
    .wdata(wdata), .rdata(rdata), .busy(busy), .line_pitch(line_pitch),
    .start_word(start_word));

  always #10 clk = ~clk;

  logic [32:0] exp_q[$];
  int          sel_q[$];
  string       tag_q[$];
  event        chk_ev;

  always begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      logic [32:0] e, a;
      int s;
      string t;
      e = exp_q.pop_front(); s = sel_q.pop_front(); t = tag_q.pop_front();
      case (s)
        0: a = {17'b0, rdata};
        1: a = {15'b0, line_pitch};
        2: a = start_word;
        default: a = {32'b0, busy};
      endcase
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: got %0h expected %0h", t, a, e);
      end
    end
  end

  task automatic expect_v(int sel, logic [32:0] e, string t);
    exp_q.push_back(e); sel_q.push_back(sel); tag_q.push_back(t);
    -> chk_ev;
    #1;
  endtask

  task automatic wr_idx(logic [15:0] v);
    @(negedge clk); idx_we = 1; wdata = v;
    @(negedge clk); idx_we = 0;
  endtask

  task automatic wr_dat(logic [15:0] v);
    @(negedge clk); data_we = 1; wdata = v;
    @(negedge clk); data_we = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic put(logic [15:0] i, logic [15:0] v);
    wr_idx(i); wr_dat(v); wait_idle();
  endtask

  task automatic rd(logic [15:0] i, logic [15:0] e, string t);
    wr_idx(i); expect_v(0, {17'b0, e}, t);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    expect_v(3, 0, "R1 busy"); expect_v(1, 0, "R1 pitch"); expect_v(2, 0, "R1 start");
    rd(0, 16'hD0A0, "R1 id");
    for (int i = 1; i <= 8; i++) rd(16'(i), 16'd0, "R1 reg");
    // R2
    put(0, 16'hD0A2); rd(0, 16'hD0A2, "R2 accept");
    put(0, 16'hD0A5); rd(0, 16'hD0A2, "R2 reject");
    put(0, 16'hD0A1); rd(0, 16'hD0A1, "R2 accept1");
    // R3
    put(1, 640);  rd(1, 640,  "R3 x ok");
    put(1, 644);  rd(1, 640,  "R3 x not mult8");
    put(1, 1608); rd(1, 640,  "R3 x over max");
    put(1, 1600); rd(1, 1600, "R3 x at max");
    put(1, 640);
    put(2, 1201); rd(2, 0,    "R3 y over max");
    put(2, 1200); rd(2, 1200, "R3 y at max");
    put(2, 480);  rd(2, 480,  "R3 y ok");
    // R4
    put(3, 0);  rd(3, 8,  "R4 zero as 8");
    put(3, 12); rd(3, 8,  "R4 reject 12");
    put(3, 24); rd(3, 24, "R4 accept 24");
    put(3, 16); rd(3, 16, "R4 accept 16");
    // R5
    put(4, 16'h01FF); rd(4, 16'h003F, "R5 mask");
    put(4, 16'h0045); rd(4, 16'h0005, "R5 mask2");
    // R6
    wr_idx(5); wr_dat(600);
    expect_v(3, 0, "R6 no busy"); rd(5, 0, "R6 vwidth kept"); expect_v(1, 0, "R6 pitch kept");
    // R7 with R10 collision
    wr_idx(5); wr_dat(800);
    expect_v(3, 1, "R10 busy raised");
    wr_dat(1000);
    wait_idle();
    rd(5, 800, "R10 busy write dropped");
    expect_v(1, 1600, "R7 pitch 16bpp");
    rd(6, 2621, "R7 vheight 16bpp");
    // R9
    put(7, 10); expect_v(2, 5, "R9 x only");
    put(8, 3);  expect_v(2, 1205, "R9 x and y");
    // R12
    wr_idx(3);
    @(negedge clk); idx_we = 1; data_we = 1; wdata = 8;
    @(negedge clk); idx_we = 0; data_we = 0;
    expect_v(0, 3, "R12 index moved, yoff kept");
    rd(3, 16, "R12 depth kept");
    // R9 at depth 4
    put(3, 4); put(7, 10); expect_v(2, 1201, "R9 4bpp");
    // R7 4bpp and R10 window length
    wr_idx(5); wr_dat(1024);
    begin
      int c = 0;
      while (busy) begin c++; @(negedge clk); end
      expect_v(3, 0, "R10 idle");
      exp_q.push_back(33'(DW)); sel_q.push_back(4); tag_q.push_back("R10 busy length");
      n_chk++;
      void'(exp_q.pop_back()); void'(sel_q.pop_back()); void'(tag_q.pop_back());
      if (c != DW) begin n_fail++; $display("FAIL R10 busy length: got %0d expected %0d", c, DW); end
    end
    expect_v(1, 512, "R7 pitch 4bpp");
    rd(6, 8192, "R7 vheight 4bpp");
    // R7 32bpp
    put(3, 32); put(5, 640);
    expect_v(1, 2560, "R7 pitch 32bpp");
    rd(6, 1638, "R7 vheight 32bpp");
    // R8
    put(2, 1200); put(5, 1600);
    rd(5, 640, "R8 width kept"); expect_v(1, 2560, "R8 pitch kept"); rd(6, 1638, "R8 height kept");
    // R7 saturation
    put(1, 0); put(3, 8); put(5, 32);
    expect_v(1, 32, "R7 pitch small"); rd(6, 16'hFFFF, "R7 saturate");
    // R11
    rd(9, 0, "R11 idx 9");
    rd(16'hFFFF, 0, "R11 idx max");
    wr_idx(6); wr_dat(5); expect_v(0, 16'hFFFF, "R11 vheight read-only");
    rd(4, 16'h0005, "R11 bank readback");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule